// File: doc/BRIEF.md
# Signed Multiply Unit with High/Low Pair Fusion

This execution unit sits in the multiply slot of a 32-bit integer pipeline. It takes an R-type instruction word together with the two source operand values already read from the register file. It decodes the two signed multiply forms: the high form returns the upper XLEN bits of the 2×XLEN-bit signed product, and the low form returns the lower XLEN bits. The result leaves the unit with a valid strobe and the destination register index. Any other encoding is flagged as illegal and produces no result.

Software often issues a high multiply and then a low multiply on the same sources to form a full-width product. The unit keeps the product of the last high multiply. When the very next accepted instruction is a low multiply that names the same two source registers in the same order, the unit answers it from that stored product after one cycle, without multiplying again. Fusion is refused when the high multiply overwrote one of its own sources, because the register values would have changed.

Top module: `smul_unit`

## Requirements
- R1: Fields are decoded as opcode = bits 6..0, rd = 11..7, funct3 = 14..12, rs1 = 19..15, rs2 = 24..20, funct7 = 31..25. Opcode 0110011 with funct7 0000001 and funct3 001 is the high multiply, which returns bits 2·XLEN-1..XLEN of the product.
- R2: The same opcode and funct7 with funct3 000 is the low multiply, which returns bits XLEN-1..0 of the product.
- R3: Both operands are signed two's complement. This includes most-negative × most-negative, which gives upper half 0x40000000 for XLEN = 32.
- R4: Any other encoding raises `out_illegal` for exactly one cycle, visible after the first clock edge following acceptance. It never produces `out_valid`.
- R5: A multiply accepted on an edge drives `out_valid` high after the second edge that follows, and not after the first.
- R6: `in_ready` is low for exactly the one cycle after a high multiply is accepted. Otherwise it stays high, including after a low multiply.
- R7: A low multiply accepted as the very next instruction after a high multiply, with the same rs1 and the same rs2, returns the lower half of the stored product after the first edge following acceptance. The operand inputs presented with it are ignored.
- R8: With rs1 and rs2 swapped relative to the high multiply, the pair is not fused. The low multiply is computed from its own operands with the normal latency.
- R9: When the high multiply's rd equals its rs1 or its rs2, the following low multiply is not fused.
- R10: Any accepted instruction between the pair, including an illegal one, prevents fusion.
- R11: After reset, `in_ready` is high, `out_valid` and `out_illegal` are low, and no fusion record is held.
- R12: `out_rd` carries the rd field of the instruction whose result is on `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are presented |
| in_ready | output | 1 | Unit can accept this cycle |
| in_instr | input | 32 | R-type instruction word |
| in_opa | input | XLEN | Value of source register rs1 |
| in_opb | input | XLEN | Value of source register rs2 |
| out_valid | output | 1 | Result strobe |
| out_illegal | output | 1 | One-cycle pulse for an unrecognised encoding |
| out_rd | output | 5 | Destination register index of the result |
| out_data | output | XLEN | Result value |

## Verification
A stale or wrong fusion record appears at the ports one cycle after the low multiply is accepted. The result either comes a cycle too early with the previous product's low half, or it comes a cycle late and is computed from the operands presented. For this reason each fusion test presents operands on the low multiply that differ from those of the high multiply. A swapped half select, or a sign extension missing at the top of the product, corrupts `out_data` two cycles after acceptance, and the corner operands make it visible. A stall flag that is stuck shows as `in_ready` staying wrong on the cycle after a high multiply.

// File: rtl/smul_pkg.sv
package smul_pkg;
  localparam int ILEN = 32;
  localparam int IDXW = 5;

  localparam logic [6:0] OPC_REG_ALU = 7'b0110011;
  localparam logic [6:0] F7_MULDIV   = 7'b0000001;
  localparam logic [2:0] F3_LOW      = 3'b000;
  localparam logic [2:0] F3_HIGH     = 3'b001;

  typedef enum logic [1:0] {
    K_BAD  = 2'd0,
    K_LOW  = 2'd1,
    K_HIGH = 2'd2
  } kind_e;

  typedef struct packed {
    kind_e           kind;
    logic [IDXW-1:0] rd;
    logic [IDXW-1:0] rs1;
    logic [IDXW-1:0] rs2;
  } dec_t;
endpackage

// File: rtl/smul_decode.sv
module smul_decode
  import smul_pkg::*;
(
  input  logic [ILEN-1:0] instr,
  output dec_t            dec
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;

  assign opc = instr[6:0];
  assign f3  = instr[14:12];
  assign f7  = instr[31:25];

  always_comb begin
    dec.rd   = instr[11:7];
    dec.rs1  = instr[19:15];
    dec.rs2  = instr[24:20];
    dec.kind = K_BAD;
    if (opc == OPC_REG_ALU && f7 == F7_MULDIV) begin
      if (f3 == F3_HIGH)     dec.kind = K_HIGH;
      else if (f3 == F3_LOW) dec.kind = K_LOW;
    end
  end
endmodule

// File: rtl/smul_fuse.sv
module smul_fuse
  import smul_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  dec_t dec,
  output logic hit
);
  logic            rec_valid;
  logic [IDXW-1:0] rec_rs1;
  logic [IDXW-1:0] rec_rs2;
  logic            clash;

  assign clash = (dec.rd == dec.rs1) || (dec.rd == dec.rs2);
  assign hit   = rec_valid && (dec.kind == K_LOW) &&
                 (dec.rs1 == rec_rs1) && (dec.rs2 == rec_rs2);

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_valid <= 1'b0;
      rec_rs1   <= '0;
      rec_rs2   <= '0;
    end else if (accept) begin
      rec_valid <= (dec.kind == K_HIGH) && !clash;
      rec_rs1   <= dec.rs1;
      rec_rs2   <= dec.rs2;
    end
  end
endmodule

// File: rtl/smul_mult.sv
module smul_mult #(
  parameter int XLEN = 32,
  parameter int IDXW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [XLEN-1:0]   a,
  input  logic [XLEN-1:0]   b,
  input  logic              hi,
  input  logic [IDXW-1:0]   rd,
  output logic              busy_hi,
  output logic              done,
  output logic              done_hi,
  output logic [IDXW-1:0]   done_rd,
  output logic [2*XLEN-1:0] prod
);
  localparam int PW = 2 * XLEN;

  logic            s1_v;
  logic [XLEN-1:0] s1_a;
  logic [XLEN-1:0] s1_b;
  logic            s1_hi;
  logic [IDXW-1:0] s1_rd;
  logic signed [PW-1:0] ext_a;
  logic signed [PW-1:0] ext_b;
  logic signed [PW-1:0] full;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v  <= 1'b0;
      s1_a  <= '0;
      s1_b  <= '0;
      s1_hi <= 1'b0;
      s1_rd <= '0;
    end else begin
      s1_v <= go;
      if (go) begin
        s1_a  <= a;
        s1_b  <= b;
        s1_hi <= hi;
        s1_rd <= rd;
      end
    end
  end

  assign ext_a   = {{XLEN{s1_a[XLEN-1]}}, s1_a};
  assign ext_b   = {{XLEN{s1_b[XLEN-1]}}, s1_b};
  assign full    = ext_a * ext_b;
  assign busy_hi = s1_v && s1_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      done_hi <= 1'b0;
      done_rd <= '0;
      prod    <= '0;
    end else begin
      done <= s1_v;
      if (s1_v) begin
        prod    <= full;
        done_hi <= s1_hi;
        done_rd <= s1_rd;
      end
    end
  end
endmodule

// File: rtl/smul_unit.sv
module smul_unit
  import smul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_instr,
  input  logic [XLEN-1:0] in_opa,
  input  logic [XLEN-1:0] in_opb,
  output logic            out_valid,
  output logic            out_illegal,
  output logic [4:0]      out_rd,
  output logic [XLEN-1:0] out_data
);
  localparam int PW = 2 * XLEN;

  dec_t            dec;
  logic            accept;
  logic            hit;
  logic            go;
  logic            busy_hi;
  logic            mul_done;
  logic            done_hi;
  logic [IDXW-1:0] done_rd;
  logic [PW-1:0]   prod;
  logic            fz_valid;
  logic [IDXW-1:0] fz_rd;
  logic            bad_q;

  smul_decode u_dec (
    .instr (in_instr),
    .dec   (dec)
  );

  assign in_ready = !busy_hi;
  assign accept   = in_valid && in_ready;
  assign go       = accept && (dec.kind != K_BAD) && !hit;

  smul_fuse u_fuse (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .dec    (dec),
    .hit    (hit)
  );

  smul_mult #(.XLEN(XLEN), .IDXW(IDXW)) u_mult (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .a       (in_opa),
    .b       (in_opb),
    .hi      (dec.kind == K_HIGH),
    .rd      (dec.rd),
    .busy_hi (busy_hi),
    .done    (mul_done),
    .done_hi (done_hi),
    .done_rd (done_rd),
    .prod    (prod)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fz_valid <= 1'b0;
      fz_rd    <= '0;
      bad_q    <= 1'b0;
    end else begin
      fz_valid <= accept && hit;
      fz_rd    <= dec.rd;
      bad_q    <= accept && (dec.kind == K_BAD);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_rd      <= '0;
      out_data    <= '0;
    end else begin
      out_valid   <= mul_done || fz_valid;
      out_illegal <= bad_q;
      out_rd      <= mul_done ? done_rd : fz_rd;
      out_data    <= (mul_done && done_hi) ? prod[PW-1:XLEN] : prod[XLEN-1:0];
    end
  end
endmodule

// File: rtl/smul_unit_chk.sv
module smul_unit_chk
  import smul_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_instr,
  input logic        out_valid,
  input logic        out_illegal,
  input logic        fz_valid,
  input logic        mul_done
);
  logic acc;
  logic is_muldiv;
  logic is_hi;
  logic is_lo;

  assign acc       = in_valid && in_ready;
  assign is_muldiv = (in_instr[6:0] == OPC_REG_ALU) && (in_instr[31:25] == F7_MULDIV);
  assign is_hi     = is_muldiv && (in_instr[14:12] == F3_HIGH);
  assign is_lo     = is_muldiv && (in_instr[14:12] == F3_LOW);

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (in_ready && !out_valid && !out_illegal)); // R11

  AST_STALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst)
    (acc && is_hi) |=> !in_ready); // R6

  AST_HIGH_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (acc && is_hi) |=> ##2 out_valid); // R5

  AST_BAD_PULSE: assert property (@(posedge clk) disable iff (rst)
    (acc && !is_hi && !is_lo) |=> ##1 out_illegal); // R4

  AST_BAD_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
    (acc && !is_hi && !is_lo) |=> ##2 !out_valid); // R4

  AST_FUSED_NEXT: assert property (@(posedge clk) disable iff (rst)
    fz_valid |=> out_valid); // R7

  AST_PATHS_DISJOINT: assert property (@(posedge clk) disable iff (rst)
    !(fz_valid && mul_done)); // R7
endmodule

bind smul_unit smul_unit_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_instr    (in_instr),
  .out_valid   (out_valid),
  .out_illegal (out_illegal),
  .fz_valid    (fz_valid),
  .mul_done    (mul_done)
);

// File: tb/tb_smul_unit.sv
module tb_smul_unit;
  localparam int XLEN       = 32;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] OPC = 7'b0110011;
  localparam logic [6:0] F7M = 7'b0000001;
  localparam logic [31:0] MINV = 32'h8000_0000;
  localparam logic [31:0] MAXV = 32'h7fff_ffff;
  localparam logic [31:0] NEG1 = 32'hffff_ffff;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [31:0]     in_instr = '0;
  logic [XLEN-1:0] in_opa = '0;
  logic [XLEN-1:0] in_opb = '0;
  logic            out_valid;
  logic            out_illegal;
  logic [4:0]      out_rd;
  logic [XLEN-1:0] out_data;

  int n_chk = 0;
  int n_bad = 0;

  smul_unit #(.XLEN(XLEN)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_opa(in_opa), .in_opb(in_opb),
    .out_valid(out_valid), .out_illegal(out_illegal),
    .out_rd(out_rd), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  function automatic logic [31:0] enc(logic [2:0] f3, logic [4:0] rs1, logic [4:0] rs2,
                                      logic [4:0] rd);
    return {F7M, rs2, rs1, f3, rd, OPC};
  endfunction

  function automatic logic [63:0] ref64(logic [31:0] a, logic [31:0] b);
    logic signed [63:0] sa;
    logic signed [63:0] sb;
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    return sa * sb;
  endfunction

  // Called at a falling edge; returns at the falling edge after the accepting edge.
  task automatic send(logic [31:0] w, logic [31:0] a, logic [31:0] b);
    in_valid = 1'b1;
    in_instr = w;
    in_opa   = a;
    in_opb   = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_instr = '0;
  endtask

  task automatic t_reset();
    chk("R11 in_ready", 64'(in_ready), 64'd1);
    chk("R11 out_valid", 64'(out_valid), 64'd0);
    chk("R11 out_illegal", 64'(out_illegal), 64'd0);
  endtask

  task automatic t_single(string tag, bit hi, logic [31:0] a, logic [31:0] b,
                          logic [4:0] rs1, logic [4:0] rs2, logic [4:0] rd);
    logic [63:0] p;
    p = ref64(a, b);
    repeat (2) @(negedge clk);
    send(enc(hi ? 3'b001 : 3'b000, rs1, rs2, rd), a, b);
    chk({"R6 ready ", tag}, 64'(in_ready), hi ? 64'd0 : 64'd1);
    @(negedge clk);
    chk({"R5 early ", tag}, 64'(out_valid), 64'd0);
    @(negedge clk);
    chk({"R5 valid ", tag}, 64'(out_valid), 64'd1);
    chk({"R12 rd ", tag}, 64'(out_rd), 64'(rd));
    chk(tag, 64'(out_data), hi ? 64'(p[63:32]) : 64'(p[31:0]));
  endtask

  task automatic t_illegal(string tag, logic [31:0] w);
    repeat (2) @(negedge clk);
    send(w, 32'h1234_5678, 32'h9abc_def0);
    @(negedge clk);
    chk({"R4 pulse ", tag}, 64'(out_illegal), 64'd1);
    @(negedge clk);
    chk({"R4 pulse end ", tag}, 64'(out_illegal), 64'd0);
    chk({"R4 no result ", tag}, 64'(out_valid), 64'd0);
  endtask

  // High multiply then low multiply; fused pairs must answer from the stored product.
  task automatic t_pair(string tag, logic [4:0] h1, logic [4:0] h2, logic [4:0] hrd,
                        logic [4:0] l1, logic [4:0] l2, logic [4:0] lrd,
                        logic [31:0] a, logic [31:0] b, logic [31:0] a2, logic [31:0] b2,
                        bit fused, bit gap);
    logic [63:0] p1;
    logic [63:0] p2;
    p1 = ref64(a, b);
    p2 = ref64(a2, b2);
    repeat (2) @(negedge clk);
    send(enc(3'b001, h1, h2, hrd), a, b);
    chk({"R6 stall ", tag}, 64'(in_ready), 64'd0);
    @(negedge clk);
    if (gap) begin
      send(32'h0000_0013, 32'd0, 32'd0);
      chk({"R1 high ", tag}, 64'(out_data), 64'(p1[63:32]));
      send(enc(3'b000, l1, l2, lrd), a2, b2);
      chk({"R10 gap flag ", tag}, 64'(out_illegal), 64'd1);
      @(negedge clk);
      chk({"R10 not early ", tag}, 64'(out_valid), 64'd0);
      @(negedge clk);
      chk({"R10 valid ", tag}, 64'(out_valid), 64'd1);
      chk({"R10 data ", tag}, 64'(out_data), 64'(p2[31:0]));
    end else begin
      send(enc(3'b000, l1, l2, lrd), a2, b2);
      chk({"R1 high valid ", tag}, 64'(out_valid), 64'd1);
      chk({"R1 high ", tag}, 64'(out_data), 64'(p1[63:32]));
      @(negedge clk);
      if (fused) begin
        chk({"R7 valid ", tag}, 64'(out_valid), 64'd1);
        chk({"R7 rd ", tag}, 64'(out_rd), 64'(lrd));
        chk({"R7 data ", tag}, 64'(out_data), 64'(p1[31:0]));
      end else begin
        chk({"R8 R9 not early ", tag}, 64'(out_valid), 64'd0);
        @(negedge clk);
        chk({"R8 R9 valid ", tag}, 64'(out_valid), 64'd1);
        chk({"R8 R9 data ", tag}, 64'(out_data), 64'(p2[31:0]));
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();

    t_single("R3 min*min high", 1'b1, MINV, MINV, 5'd1, 5'd2, 5'd3);
    t_single("R3 -1*-1 high", 1'b1, NEG1, NEG1, 5'd4, 5'd5, 5'd6);
    t_single("R1 -1*1 high", 1'b1, NEG1, 32'd1, 5'd7, 5'd8, 5'd9);
    t_single("R1 max*max high", 1'b1, MAXV, MAXV, 5'd10, 5'd11, 5'd12);
    t_single("R3 min*max high", 1'b1, MINV, MAXV, 5'd13, 5'd14, 5'd15);
    t_single("R2 min*-1 low", 1'b0, MINV, NEG1, 5'd16, 5'd17, 5'd18);
    t_single("R2 zero low", 1'b0, 32'd0, 32'hdead_beef, 5'd19, 5'd20, 5'd21);
    t_single("R2 mixed low", 1'b0, 32'hfff0_0001, 32'h0012_3456, 5'd22, 5'd23, 5'd24);
    t_single("R1 zero high", 1'b1, 32'd0, NEG1, 5'd25, 5'd26, 5'd27);

    t_illegal("funct3 010", {F7M, 5'd2, 5'd1, 3'b010, 5'd3, OPC});
    t_illegal("funct7 0", {7'b0, 5'd2, 5'd1, 3'b000, 5'd3, OPC});
    t_illegal("opcode", {F7M, 5'd2, 5'd1, 3'b001, 5'd3, 7'b0010011});

    t_pair("fused", 5'd10, 5'd11, 5'd12, 5'd10, 5'd11, 5'd13,
           32'h8765_4321, 32'hfedc_ba98, 32'h1111_1111, 32'h2222_2222, 1'b1, 1'b0);
    t_pair("fused min", 5'd3, 5'd4, 5'd5, 5'd3, 5'd4, 5'd6,
           MINV, MINV, 32'd3, 32'd5, 1'b1, 1'b0);
    t_pair("R8 swapped", 5'd10, 5'd11, 5'd12, 5'd11, 5'd10, 5'd13,
           32'h0bad_cafe, 32'hf00d_1234, 32'h0000_0007, 32'hffff_fff9, 1'b0, 1'b0);
    t_pair("R9 rd=rs1", 5'd10, 5'd11, 5'd10, 5'd10, 5'd11, 5'd13,
           32'h7654_3210, 32'h8000_0001, 32'h0000_0010, 32'h0000_0020, 1'b0, 1'b0);
    t_pair("R9 rd=rs2", 5'd10, 5'd11, 5'd11, 5'd10, 5'd11, 5'd13,
           32'h7654_3210, 32'h8000_0001, 32'hffff_0000, 32'h0001_0000, 1'b0, 1'b0);
    t_pair("R10 illegal between", 5'd10, 5'd11, 5'd12, 5'd10, 5'd11, 5'd13,
           32'h5555_5555, 32'haaaa_aaaa, 32'h0000_0009, 32'h0000_000b, 1'b0, 1'b1);

    repeat (4) @(negedge clk);
    report();
    $finish;
  end
endmodule